// File: doc/BRIEF.md
# Chainable Event Counter Pair

The block holds two 64-bit event counters of the kind used in a processor performance monitor. Each counter has a 2-bit source select. The source can be off, an external event pulse, a software-increment write, or a chain event. A control input chooses where overflow is flagged: at the 32-bit boundary or at the 64-bit boundary. The counters always keep the full 64-bit value, so in 32-bit mode the count carries on into the upper half when the low half wraps.

In 32-bit mode, an overflow of the even counter (index 0) is the chain event. The odd counter (index 1) can count that event, so the pair behaves as one wider counter. Software can load either counter directly. The overflow flags are sticky. Writing a 1 to a flag's position clears that flag.

Top module: `evt_ctr_pair`

## Requirements
- R1: After reset both counters read 0 and both overflow flags read 0.
- R2: With `long_ovf`=0, a counter step that takes the low 32 bits from all ones to 0 is an overflow, and the carry goes into the upper 32 bits. For example, loading 0xFFFF_FFF0 and then applying 100 steps gives 0x1_0000_0054.
- R3: With `long_ovf`=1, an overflow occurs only when the full 64-bit value wraps from all ones to 0. A carry out of the low 32 bits is not an overflow in this mode.
- R4: An overflow of counter k sets bit k of `ovf_sts`. The bit then stays set until it is cleared. When both counters have overflowed, `ovf_sts` reads 0x3.
- R5: A cycle with `swinc_wr`=1 increments each counter k that meets all three conditions: `swinc_mask[k]`=1, its source is software increment, and it is enabled. A mask of 0x1 increments counter 0 only.
- R6: A cycle with `ovf_clr_wr`=1 clears each `ovf_sts` bit whose `ovf_clr_mask` bit is 1. Bits whose mask bit is 0 are left unchanged.
- R7: With `long_ovf`=0, counter 1 in chain mode increments by 1 in the same cycle that counter 0 overflows. When counter 1 is preloaded to 0xFFFF_FFFF, one chain step makes its low half 0 and sets `ovf_sts[1]`.
- R8: With `long_ovf`=1, counter 0 overflowing produces no chain event, and counter 1 in chain mode does not change.
- R9: A counter steps only when `glb_en`=1 and its own `cnt_en` bit is 1. In any other cycle, events have no effect on it.
- R10: When `ld_wr[k]` is set in the same cycle as an event for counter k, counter k takes `ld_data` and does not step. A load never raises an overflow.
- R11: If a flag's overflow and its clear arrive in the same cycle, the flag ends up set.
- R12: The source select codes are:
  - 0: off.
  - 1: external pulse `ext_evt[k]`.
  - 2: software increment.
  - 3: chain.

  Each counter counts only its selected source. Counter 0 set to chain never counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| glb_en | input | 1 | Global count enable |
| long_ovf | input | 1 | 1: overflow at 64 bits; 0: overflow at 32 bits |
| cnt_en | input | 2 | Per-counter enable |
| src0 | input | 2 | Source select for counter 0 |
| src1 | input | 2 | Source select for counter 1 |
| ext_evt | input | 2 | External event pulse per counter |
| swinc_wr | input | 1 | Software-increment write strobe |
| swinc_mask | input | 2 | Software-increment mask |
| ld_wr | input | 2 | Direct load strobe per counter |
| ld_data | input | 64 | Load value |
| ovf_clr_wr | input | 1 | Overflow clear strobe |
| ovf_clr_mask | input | 2 | Flags to clear |
| cnt0 | output | 64 | Counter 0 value |
| cnt1 | output | 64 | Counter 1 value |
| ovf_sts | output | 2 | Sticky overflow flags |

## Verification
The bench targets five corner cases:
- **Carry across the 32-bit boundary.** A design that cleared the upper half would give 0x54 instead of 0x1_0000_0054. A design that flagged overflow in 64-bit mode would set the flag too early.
- **Chain timing.** A chain that arrived one cycle late, or that fired in 64-bit mode, would leave counter 1 off by one or stepping when it should hold.
- **Load against step collision.** A design that let the step win would read the loaded value plus one.
- **Set against clear collision.** A design that let the clear win would lose an overflow.
- **Masked and disabled sources.** These include external pulses to a counter in chain mode and chain mode on counter 0. They are checked at the counter outputs to show that nothing moved.

// File: rtl/evt_ctr_pkg.sv
package evt_ctr_pkg;
  localparam int CTR_W   = 64;
  localparam int SHORT_W = 32;
  localparam int PAIR_N  = 2;

  typedef enum logic [1:0] {
    SRC_OFF   = 2'd0,
    SRC_EXT   = 2'd1,
    SRC_SWINC = 2'd2,
    SRC_CHAIN = 2'd3
  } evt_src_e;
endpackage

// File: rtl/evt_src_sel.sv
module evt_src_sel
  import evt_ctr_pkg::*;
(
  input  evt_src_e src,
  input  logic     active,
  input  logic     ext_hit,
  input  logic     sw_hit,
  input  logic     chain_hit,
  output logic     step
);
  always_comb begin
    unique case (src)
      SRC_EXT:   step = active & ext_hit;
      SRC_SWINC: step = active & sw_hit;
      SRC_CHAIN: step = active & chain_hit;
      default:   step = 1'b0;
    endcase
  end
endmodule

// File: rtl/evt_ctr_slice.sv
module evt_ctr_slice #(
  parameter int W  = evt_ctr_pkg::CTR_W,
  parameter int SW = evt_ctr_pkg::SHORT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         long_mode,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         step,
  output logic [W-1:0] value,
  output logic         ovf_evt
);
  // Returns 1 when a +1 step from val wraps at the active boundary.
  function automatic logic at_wrap(input logic [W-1:0] val, input logic lng);
    if (lng) return &val;
    return &val[SW-1:0];
  endfunction

  function automatic logic [W-1:0] bump(input logic [W-1:0] val);
    return val + {{(W-1){1'b0}}, 1'b1};
  endfunction

  logic do_step;
  assign do_step = step & ~ld;
  assign ovf_evt = do_step & at_wrap(value, long_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       value <= '0;
    else if (ld)      value <= ld_val;
    else if (do_step) value <= bump(value);
  end
endmodule

// File: rtl/evt_ovf_status.sv
module evt_ovf_status #(
  parameter int N = evt_ctr_pkg::PAIR_N
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_evt,
  input  logic         clr_wr,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] flags
);
  logic [N-1:0] clr_vec;
  assign clr_vec = clr_wr ? clr_mask : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr_vec) | set_evt;
  end
endmodule

// File: rtl/evt_ctr_pair.sv
module evt_ctr_pair
  import evt_ctr_pkg::*;
#(
  parameter int W  = CTR_W,
  parameter int SW = SHORT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         glb_en,
  input  logic         long_ovf,
  input  logic [1:0]   cnt_en,
  input  logic [1:0]   src0,
  input  logic [1:0]   src1,
  input  logic [1:0]   ext_evt,
  input  logic         swinc_wr,
  input  logic [1:0]   swinc_mask,
  input  logic [1:0]   ld_wr,
  input  logic [W-1:0] ld_data,
  input  logic         ovf_clr_wr,
  input  logic [1:0]   ovf_clr_mask,
  output logic [W-1:0] cnt0,
  output logic [W-1:0] cnt1,
  output logic [1:0]   ovf_sts
);
  localparam int N = 2;

  evt_src_e     src   [N];
  logic [W-1:0] value [N];
  logic [N-1:0] step;
  logic [N-1:0] ovf_evt;   // named event wires for the checker
  logic [N-1:0] chain_hit;

  assign src[0] = evt_src_e'(src0);
  assign src[1] = evt_src_e'(src1);

  for (genvar k = 0; k < N; k++) begin : g_ctr
    if (k % 2 == 1) begin : g_odd
      assign chain_hit[k] = ovf_evt[k-1] & ~long_ovf;
    end else begin : g_even
      assign chain_hit[k] = 1'b0;
    end

    evt_src_sel u_sel (
      .src       (src[k]),
      .active    (glb_en & cnt_en[k]),
      .ext_hit   (ext_evt[k]),
      .sw_hit    (swinc_wr & swinc_mask[k]),
      .chain_hit (chain_hit[k]),
      .step      (step[k])
    );

    evt_ctr_slice #(.W(W), .SW(SW)) u_slice (
      .clk       (clk),
      .rst_n     (rst_n),
      .long_mode (long_ovf),
      .ld        (ld_wr[k]),
      .ld_val    (ld_data),
      .step      (step[k]),
      .value     (value[k]),
      .ovf_evt   (ovf_evt[k])
    );
  end

  evt_ovf_status #(.N(N)) u_sts (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_evt  (ovf_evt),
    .clr_wr   (ovf_clr_wr),
    .clr_mask (ovf_clr_mask),
    .flags    (ovf_sts)
  );

  assign cnt0 = value[0];
  assign cnt1 = value[1];
endmodule

// File: rtl/evt_ctr_pair_chk.sv
module evt_ctr_pair_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        glb_en,
  input logic        long_ovf,
  input logic [1:0]  cnt_en,
  input logic [1:0]  src1,
  input logic [1:0]  ld_wr,
  input logic [63:0] ld_data,
  input logic        ovf_clr_wr,
  input logic [1:0]  ovf_clr_mask,
  input logic [63:0] cnt0,
  input logic [63:0] cnt1,
  input logic [1:0]  ovf_sts,
  input logic [1:0]  ovf_evt
);
  assert_load_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ld_wr[0] |=> cnt0 == $past(ld_data));

  assert_hold_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!glb_en && ld_wr == 2'b00) |=> (cnt0 == $past(cnt0) && cnt1 == $past(cnt1)));

  assert_flag_on_ovf_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt[0] |=> ovf_sts[0]);

  assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_sts[1] && !(ovf_clr_wr && ovf_clr_mask[1])) |=> ovf_sts[1]);

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_clr_wr && ovf_clr_mask[0] && !ovf_evt[0]) |=> !ovf_sts[0]);

  assert_no_chain_long_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (long_ovf && src1 == 2'd3 && !ld_wr[1]) |=> cnt1 == $past(cnt1));

  assert_chain_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!long_ovf && src1 == 2'd3 && glb_en && cnt_en[1] && ovf_evt[0] && !ld_wr[1])
    |=> cnt1 == $past(cnt1) + 64'd1);

  assert_unit_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_wr[0] |=> (cnt0 == $past(cnt0) || cnt0 == $past(cnt0) + 64'd1));
endmodule

bind evt_ctr_pair evt_ctr_pair_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .glb_en       (glb_en),
  .long_ovf     (long_ovf),
  .cnt_en       (cnt_en),
  .src1         (src1),
  .ld_wr        (ld_wr),
  .ld_data      (ld_data),
  .ovf_clr_wr   (ovf_clr_wr),
  .ovf_clr_mask (ovf_clr_mask),
  .cnt0         (cnt0),
  .cnt1         (cnt1),
  .ovf_sts      (ovf_sts),
  .ovf_evt      (ovf_evt)
);

// File: tb/evt_ctr_pair_bench.sv
module evt_ctr_pair_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        glb_en, long_ovf, swinc_wr, ovf_clr_wr;
  logic [1:0]  cnt_en, src0, src1, ext_evt, swinc_mask, ld_wr, ovf_clr_mask;
  logic [63:0] ld_data, cnt0, cnt1;
  logic [1:0]  ovf_sts;

  int n_run = 0, n_fail = 0;
  string cur_req = "R1";
  logic [63:0] m_cnt [2];
  logic [1:0]  m_ovf;

  always #4 clk = ~clk;   // 125 MHz

  evt_ctr_pair u_evt_ctr_pair (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Behavioural reference: one clock of the counter pair.
  task automatic model_step();
    bit [1:0] wrapped = 2'b00;
    for (int k = 0; k < 2; k++) begin
      int sel = (k == 0) ? int'(src0) : int'(src1);
      bit go = 0;
      if (glb_en && cnt_en[k]) begin
        if (sel == 1) go = ext_evt[k];
        if (sel == 2) go = swinc_wr && swinc_mask[k];
        if (sel == 3) go = (k == 1) && wrapped[0] && !long_ovf;
      end
      if (ld_wr[k]) m_cnt[k] = ld_data;
      else if (go) begin
        m_cnt[k] = m_cnt[k] + 1;
        wrapped[k] = long_ovf ? (m_cnt[k] == 0) : ((m_cnt[k] & 64'hFFFF_FFFF) == 0);
      end
    end
    if (ovf_clr_wr) m_ovf = m_ovf & ~ovf_clr_mask;
    m_ovf = m_ovf | wrapped;
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk({cur_req, " cnt0"}, cnt0, m_cnt[0]);
    chk({cur_req, " cnt1"}, cnt1, m_cnt[1]);
    chk({cur_req, " ovf"}, {62'd0, ovf_sts}, {62'd0, m_ovf});
    ext_evt = 0; swinc_wr = 0; swinc_mask = 0; ld_wr = 0; ovf_clr_wr = 0; ovf_clr_mask = 0;
  endtask

  task automatic load(int k, logic [63:0] v);
    ld_wr[k] = 1'b1; ld_data = v; tick();
  endtask
  task automatic swinc(logic [1:0] m);
    swinc_wr = 1; swinc_mask = m; tick();
  endtask
  task automatic ext(logic [1:0] m);
    ext_evt = m; tick();
  endtask
  task automatic clr(logic [1:0] m);
    ovf_clr_wr = 1; ovf_clr_mask = m; tick();
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    rst_n = 0; glb_en = 0; long_ovf = 0; cnt_en = 0; src0 = 0; src1 = 0;
    ext_evt = 0; swinc_wr = 0; swinc_mask = 0; ld_wr = 0; ld_data = 0;
    ovf_clr_wr = 0; ovf_clr_mask = 0;
    m_cnt[0] = 0; m_cnt[1] = 0; m_ovf = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk("R1", cnt0, 64'd0); chk("R1", cnt1, 64'd0); chk("R1", {62'd0, ovf_sts}, 64'd0);

    // R2 R5: carry into upper half, software increments
    cur_req = "R2"; glb_en = 1; cnt_en = 2'b11; src0 = 2; src1 = 2;
    load(0, 64'hFFFF_FFF0);
    repeat (100) swinc(2'b11);
    chk("R2", cnt0, 64'h1_0000_0054);
    chk("R5", cnt1, 64'd100);
    chk("R4", {62'd0, ovf_sts}, 64'd1);
    cur_req = "R5"; swinc(2'b01);
    chk("R5", cnt1, 64'd100);
    chk("R5", cnt0, 64'h1_0000_0055);

    // R6: write-one-to-clear
    cur_req = "R6"; clr(2'b10);
    chk("R6", {62'd0, ovf_sts}, 64'd1);
    clr(2'b01);
    chk("R6", {62'd0, ovf_sts}, 64'd0);

    // R7: chained pair in 32-bit mode
    cur_req = "R7"; src0 = 1; src1 = 3;
    load(0, 64'hFFFF_FFF0); load(1, 64'hFFFF_FFFF);
    repeat (22) ext(2'b01);
    chk("R7", cnt0, 64'h1_0000_0006);
    chk("R7", cnt1, 64'h1_0000_0000);
    chk("R4", {62'd0, ovf_sts}, 64'd3);
    cur_req = "R12"; ext(2'b10);
    chk("R12", cnt1, 64'h1_0000_0000);

    // R3 R8: 64-bit overflow mode
    cur_req = "R3"; clr(2'b11); long_ovf = 1;
    load(0, '1); load(1, 64'd5);
    ext(2'b01);
    chk("R3", cnt0, 64'd0);
    chk("R8", cnt1, 64'd5);
    chk("R3", {62'd0, ovf_sts}, 64'd1);
    clr(2'b01);
    load(0, 64'hFFFF_FFFF); ext(2'b01);
    chk("R3", cnt0, 64'h1_0000_0000);
    chk("R3", {62'd0, ovf_sts}, 64'd0);
    src1 = 2; load(1, '1); swinc(2'b10);
    chk("R3", cnt1, 64'd0);
    chk("R3", {62'd0, ovf_sts}, 64'd2);

    // R9: enables
    cur_req = "R9"; long_ovf = 0; glb_en = 0; src0 = 2;
    swinc(2'b11);
    chk("R9", cnt1, 64'd0);
    glb_en = 1; cnt_en = 2'b10;
    swinc(2'b11);
    chk("R9", cnt0, 64'h1_0000_0000);
    chk("R9", cnt1, 64'd1);

    // R10: load beats step
    cur_req = "R10"; cnt_en = 2'b11;
    ld_wr[0] = 1; ld_data = 64'h1234; swinc_wr = 1; swinc_mask = 2'b01; tick();
    chk("R10", cnt0, 64'h1234);

    // R11: set beats clear
    cur_req = "R11"; clr(2'b11);
    load(0, 64'hFFFF_FFFF);
    swinc_wr = 1; swinc_mask = 2'b01; ovf_clr_wr = 1; ovf_clr_mask = 2'b01; tick();
    chk("R11", {62'd0, ovf_sts}, 64'd1);

    // R12: chain select on even counter never counts, off source never counts
    cur_req = "R12"; src0 = 3; src1 = 0;
    load(0, 64'h77);
    ext(2'b11); swinc(2'b11);
    chk("R12", cnt0, 64'h77);
    chk("R12", cnt1, 64'h1_0000_0000 - 64'h1_0000_0000 + 64'd1);

    summary();
  end
endmodule